// File: doc/BRIEF.md
# Stride Prefetcher with Shared-Stride Promotion

This block watches the memory accesses of a core that interleaves many hardware threads and proposes one prefetch address per access. Each access carries a program counter, a thread identifier and a byte address. A per-thread table, keyed by the PC together with the thread identifier, learns each thread's own address stride. When enough distinct threads at one PC have settled on the same stride, that stride moves into a small table keyed by PC alone. From then on every thread at that PC, including threads that have never been seen, gets a prefetch on its first access. The per-thread entries that agreed are released, so they stop taking slots in the per-thread table.

Each access goes through three registered stages. In the first stage the shared table is looked up. In the second stage, and only if that lookup missed, the per-thread table is trained and may trigger a promotion. In the third stage the response is registered. A response reporting no stride hit is the signal to a downstream inter-thread detector that it may act on the access.

Top module: `stride_promo_prefetcher`

## Requirements
- R1: While reset is high, and on the first cycle after it, `rsp_valid`, `rsp_hit` and `rsp_promo` are 0.
- R2: Each access presented with `req_valid` high produces exactly one response with `rsp_valid` high three clock cycles later. Cycles without an access produce no response.
- R3: A thread's entry at a PC hits once two consecutive address deltas at that PC and thread are equal. The prefetch address is then the current address plus that delta. Any response without a hit has `rsp_hit` = 0 and `rsp_pf_addr` = 0.
- R4: A delta that differs from the stored stride ends the hit state. The entry needs one more delta equal to the new value before it hits again.
- R5: On an access whose per-thread entry hits, the block counts the hitting entries at the same PC with the same stride, the current one included. If that count is at least `cfg_promo_need`, the block creates a shared entry (PC, stride) and frees every counted per-thread entry. The response to that access reports a per-thread hit (`rsp_promo` = 0).
- R6: An access whose PC has a shared entry responds with `rsp_hit` = 1, `rsp_promo` = 1 and address plus the shared stride, whatever its thread identifier. It neither allocates nor refreshes any per-thread entry.
- R7: The per-thread table holds `STRIDE_ENTRIES` entries. When it is full, a new (PC, thread) pair replaces the least recently allocated or hit entry.
- R8: The shared table holds `PROMO_ENTRIES` entries. When it is full, a promotion replaces the least recently created or hit shared entry.
- R9: An access that follows, in the very next cycle, an access that promotes its PC already receives the shared-table hit.
- R10: Threads at one PC that have learned different strides do not count toward each other, and no shared entry forms from them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_pc | input | PC_W | Program counter of the access |
| req_tid | input | TID_W | Thread identifier of the access |
| req_addr | input | ADDR_W | Byte address of the access |
| cfg_promo_need | input | $clog2(STRIDE_ENTRIES+1) | Number of agreeing threads needed for a promotion |
| rsp_valid | output | 1 | Response for the access presented three cycles earlier |
| rsp_hit | output | 1 | A trained stride was found |
| rsp_promo | output | 1 | The stride came from the shared table |
| rsp_pf_addr | output | ADDR_W | Proposed prefetch address, zero without a hit |

## Verification
The hardest case to reach from the ports is the pipeline overlap. An access can be looking up the shared table in the same cycle that the access ahead of it inserts a new shared entry. That insertion may create the very PC being looked up, or it may evict the entry being hit. The stimulus reaches the first case by placing a new thread's access at the promoting PC right behind the promoting access. It reaches the second by shrinking both tables through parameters and running long streams of back-to-back accesses over a few PCs and threads. A sequential model in the bench predicts every response three cycles ahead and compares it on each clock.

// File: rtl/spf_pkg.sv
package spf_pkg;

    parameter int PC_W    = 32;
    parameter int ADDR_W  = 32;
    parameter int TID_W   = 8;
    parameter int STAMP_W = 32;

    // training state of one per-thread entry
    typedef enum logic [1:0] {
        TR_EMPTY = 2'd0,   // only a base address seen
        TR_ONE   = 2'd1,   // one delta recorded
        TR_LOCK  = 2'd2    // two equal deltas in a row
    } trn_e;

    typedef struct packed {
        logic              valid;
        logic [PC_W-1:0]   pc;
        logic [TID_W-1:0]  tid;
        logic [ADDR_W-1:0] addr;
    } req_t;

    typedef struct packed {
        logic               valid;
        logic [PC_W-1:0]    pc;
        logic [ADDR_W-1:0]  stride;
        logic [STAMP_W-1:0] stamp;
    } pent_t;

    typedef struct packed {
        logic               valid;
        logic [PC_W-1:0]    pc;
        logic [TID_W-1:0]   tid;
        logic [ADDR_W-1:0]  last;
        logic [ADDR_W-1:0]  stride;
        trn_e               st;
        logic [STAMP_W-1:0] stamp;
    } sent_t;

    // advance one per-thread entry by a new address
    function automatic sent_t train_step(input sent_t e, input logic [ADDR_W-1:0] addr);
        sent_t             n;
        logic [ADDR_W-1:0] d;
        n = e;
        d = addr - e.last;
        unique case (e.st)
            TR_EMPTY: begin
                n.stride = d;
                n.st     = TR_ONE;
            end
            default: begin
                if (d == e.stride) begin
                    n.st = TR_LOCK;
                end else begin
                    n.stride = d;
                    n.st     = TR_ONE;
                end
            end
        endcase
        n.last = addr;
        return n;
    endfunction

endpackage

// File: rtl/spf_victim.sv
module spf_victim
    import spf_pkg::*;
#(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]              valid,
    input  logic [N-1:0][STAMP_W-1:0] stamp,
    output logic [IDX_W-1:0]          idx
);
    logic found_free;

    always_comb begin
        idx        = '0;
        found_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !found_free) begin
                idx        = IDX_W'(i);
                found_free = 1'b1;
            end
        end
        if (!found_free) begin
            for (int i = 1; i < N; i++) begin
                if (stamp[i] < stamp[idx]) begin
                    idx = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/spf_promo_tbl.sv
module spf_promo_tbl
    import spf_pkg::*;
#(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STAMP_W-1:0] stamp,
    input  logic               lk_en,
    input  logic [PC_W-1:0]    lk_pc,
    input  logic               ins_en,
    input  logic [PC_W-1:0]    ins_pc,
    input  logic [ADDR_W-1:0]  ins_stride,
    output logic               lk_hit,
    output logic [ADDR_W-1:0]  lk_stride
);
    pent_t                     tbl [N];
    logic [N-1:0]              v_vec;
    logic [N-1:0][STAMP_W-1:0] s_vec;
    logic [IDX_W-1:0]          vic;
    logic                      raw_hit;
    logic [IDX_W-1:0]          raw_idx;
    logic                      hit_new;

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign v_vec[g] = tbl[g].valid;
        assign s_vec[g] = tbl[g].stamp;
    end

    spf_victim #(.N(N)) u_vic (
        .valid (v_vec),
        .stamp (s_vec),
        .idx   (vic)
    );

    always_comb begin
        raw_hit = 1'b0;
        raw_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (tbl[i].valid && tbl[i].pc == lk_pc) begin
                raw_hit = 1'b1;
                raw_idx = IDX_W'(i);
            end
        end
        // the insertion of the older access counts as already done
        hit_new   = 1'b0;
        lk_hit    = 1'b0;
        lk_stride = '0;
        if (ins_en && ins_pc == lk_pc) begin
            hit_new   = lk_en;
            lk_hit    = lk_en;
            lk_stride = ins_stride;
        end else if (raw_hit && !(ins_en && raw_idx == vic)) begin
            lk_hit    = lk_en;
            lk_stride = tbl[raw_idx].stride;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                tbl[i] <= '0;
            end
        end else begin
            if (ins_en) begin
                tbl[vic].valid  <= 1'b1;
                tbl[vic].pc     <= ins_pc;
                tbl[vic].stride <= ins_stride;
                tbl[vic].stamp  <= hit_new ? stamp + STAMP_W'(1) : stamp;
            end
            if (lk_hit && !hit_new) begin
                tbl[raw_idx].stamp <= stamp + STAMP_W'(1);
            end
        end
    end
endmodule

// File: rtl/spf_stride_tbl.sv
module spf_stride_tbl
    import spf_pkg::*;
#(
    parameter int N = 64,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
    localparam int NEED_W = $clog2(N + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STAMP_W-1:0] stamp,
    input  logic               en,
    input  logic [PC_W-1:0]    pc,
    input  logic [TID_W-1:0]   tid,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NEED_W-1:0]  need,
    output logic               hit,
    output logic [ADDR_W-1:0]  stride,
    output logic               promote
);
    sent_t                     tbl [N];
    logic [N-1:0]              v_vec;
    logic [N-1:0][STAMP_W-1:0] s_vec;
    logic [IDX_W-1:0]          vic;
    logic                      found;
    logic [IDX_W-1:0]          f_idx;
    logic [IDX_W-1:0]          wr_idx;
    sent_t                     nxt;
    logic                      trained;
    logic [N-1:0]              agree;
    int                        votes;

    for (genvar g = 0; g < N; g++) begin : g_flat
        assign v_vec[g] = tbl[g].valid;
        assign s_vec[g] = tbl[g].stamp;
    end

    spf_victim #(.N(N)) u_vic (
        .valid (v_vec),
        .stamp (s_vec),
        .idx   (vic)
    );

    always_comb begin
        found = 1'b0;
        f_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (tbl[i].valid && tbl[i].pc == pc && tbl[i].tid == tid) begin
                found = 1'b1;
                f_idx = IDX_W'(i);
            end
        end
        wr_idx = found ? f_idx : vic;
        if (found) begin
            nxt = train_step(tbl[f_idx], addr);
        end else begin
            nxt        = '0;
            nxt.valid  = 1'b1;
            nxt.pc     = pc;
            nxt.tid    = tid;
            nxt.last   = addr;
            nxt.st     = TR_EMPTY;
        end
        nxt.stamp = stamp;
        trained   = (nxt.st == TR_LOCK);
    end

    // other trained threads at this PC agreeing on the new stride
    for (genvar g = 0; g < N; g++) begin : g_agree
        assign agree[g] = tbl[g].valid && tbl[g].st == TR_LOCK && tbl[g].pc == pc
                          && tbl[g].stride == nxt.stride && wr_idx != IDX_W'(g);
    end

    always_comb begin
        votes   = $countones(agree) + (trained ? 1 : 0);
        hit     = en && trained;
        stride  = nxt.stride;
        promote = en && trained && (votes >= int'(need));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                tbl[i] <= '0;
            end
        end else if (en) begin
            tbl[wr_idx] <= nxt;
            if (promote) begin
                for (int i = 0; i < N; i++) begin
                    if (agree[i]) begin
                        tbl[i].valid <= 1'b0;
                    end
                end
                tbl[wr_idx].valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/stride_promo_prefetcher.sv
module stride_promo_prefetcher
    import spf_pkg::*;
#(
    parameter int PROMO_ENTRIES  = 16,
    parameter int STRIDE_ENTRIES = 64,
    localparam int NEED_W = $clog2(STRIDE_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NEED_W-1:0] cfg_promo_need,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_promo,
    output logic [ADDR_W-1:0] rsp_pf_addr
);
    req_t               s1_q;
    req_t               s2_q;
    logic               s2_phit;
    logic [ADDR_W-1:0]  s2_pstride;
    logic [STAMP_W-1:0] stamp_q;

    logic               p_hit;
    logic [ADDR_W-1:0]  p_stride;
    logic               st_hit;
    logic [ADDR_W-1:0]  st_stride;
    logic               st_promote;
    logic               st_en;

    // stage 1: capture the access
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= '0;
            stamp_q <= '0;
        end else begin
            s1_q.valid <= req_valid;
            s1_q.pc    <= req_pc;
            s1_q.tid   <= req_tid;
            s1_q.addr  <= req_addr;
            stamp_q    <= stamp_q + STAMP_W'(2);
        end
    end

    spf_promo_tbl #(.N(PROMO_ENTRIES)) u_promo (
        .clk        (clk),
        .rst        (rst),
        .stamp      (stamp_q),
        .lk_en      (s1_q.valid),
        .lk_pc      (s1_q.pc),
        .ins_en     (st_promote),
        .ins_pc     (s2_q.pc),
        .ins_stride (st_stride),
        .lk_hit     (p_hit),
        .lk_stride  (p_stride)
    );

    // stage 2: carry the shared-table result
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q       <= '0;
            s2_phit    <= 1'b0;
            s2_pstride <= '0;
        end else begin
            s2_q       <= s1_q;
            s2_phit    <= p_hit;
            s2_pstride <= p_stride;
        end
    end

    assign st_en = s2_q.valid && !s2_phit;

    spf_stride_tbl #(.N(STRIDE_ENTRIES)) u_stride (
        .clk     (clk),
        .rst     (rst),
        .stamp   (stamp_q),
        .en      (st_en),
        .pc      (s2_q.pc),
        .tid     (s2_q.tid),
        .addr    (s2_q.addr),
        .need    (cfg_promo_need),
        .hit     (st_hit),
        .stride  (st_stride),
        .promote (st_promote)
    );

    // stage 3: registered response
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_promo   <= 1'b0;
            rsp_pf_addr <= '0;
        end else begin
            rsp_valid <= s2_q.valid;
            rsp_hit   <= s2_q.valid && (s2_phit || st_hit);
            rsp_promo <= s2_q.valid && s2_phit;
            if (s2_q.valid && s2_phit) begin
                rsp_pf_addr <= s2_q.addr + s2_pstride;
            end else if (st_hit) begin
                rsp_pf_addr <= s2_q.addr + st_stride;
            end else begin
                rsp_pf_addr <= '0;
            end
        end
    end
endmodule

// File: rtl/spf_checker.sv
module spf_checker
    import spf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_promo,
    input logic [ADDR_W-1:0] rsp_pf_addr,
    input logic              st_promote,
    input logic              s2_phit
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !rsp_hit && !rsp_promo));

    // R2
    a_r2_three_cycle_response: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (rsp_valid == $past(req_valid, 3)));

    // R3
    a_r3_miss_has_zero_addr: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_pf_addr == '0));

    // R6
    a_r6_shared_is_hit: assert property (@(posedge clk) disable iff (rst)
        rsp_promo |-> (rsp_hit && rsp_valid));

    // R5
    a_r5_promote_reports_thread_hit: assert property (@(posedge clk) disable iff (rst)
        st_promote |=> (rsp_hit && !rsp_promo));

    // R6
    a_r6_no_training_on_shared_hit: assert property (@(posedge clk) disable iff (rst)
        s2_phit |-> !st_promote);
endmodule

bind stride_promo_prefetcher spf_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_promo   (rsp_promo),
    .rsp_pf_addr (rsp_pf_addr),
    .st_promote  (st_promote),
    .s2_phit     (s2_phit)
);

// File: tb/tb_stride_promo_prefetcher.sv
module tb_stride_promo_prefetcher;
    localparam int CLK_PERIOD = 10;
    localparam int PN = 4;
    localparam int SN = 8;
    localparam int NW = $clog2(SN + 1);
    localparam int WATCHDOG = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [31:0]   req_pc = '0;
    logic [7:0]    req_tid = '0;
    logic [31:0]   req_addr = '0;
    logic [NW-1:0] cfg_promo_need = NW'(3);
    logic          rsp_valid;
    logic          rsp_hit;
    logic          rsp_promo;
    logic [31:0]   rsp_pf_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stride_promo_prefetcher #(.PROMO_ENTRIES(PN), .STRIDE_ENTRIES(SN)) dut (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_pc         (req_pc),
        .req_tid        (req_tid),
        .req_addr       (req_addr),
        .cfg_promo_need (cfg_promo_need),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_promo      (rsp_promo),
        .rsp_pf_addr    (rsp_pf_addr)
    );

    typedef struct {
        bit          valid;
        bit          hit;
        bit          promo;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    typedef struct {
        logic [31:0] pc;
        logic [7:0]  tid;
        logic [31:0] last;
        logic [31:0] stride;
        int          st;
    } thr_t;

    typedef struct {
        logic [31:0] pc;
        logic [31:0] stride;
    } shr_t;

    thr_t thr_q[$];   // front = least recent
    shr_t shr_q[$];
    exp_t pipe [3];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   need_m   = 3;

    function automatic exp_t model(logic [31:0] pc, logic [7:0] tid, logic [31:0] addr, string tag);
        exp_t r;
        thr_t e;
        int   fi;
        int   cnt;
        r.valid = 1; r.hit = 0; r.promo = 0; r.addr = '0; r.tag = tag;
        for (int i = 0; i < shr_q.size(); i++) begin
            if (shr_q[i].pc == pc) begin
                shr_t s = shr_q[i];
                shr_q.delete(i);
                shr_q.push_back(s);
                r.hit = 1; r.promo = 1; r.addr = addr + s.stride;
                return r;
            end
        end
        fi = -1;
        for (int i = 0; i < thr_q.size(); i++) begin
            if (thr_q[i].pc == pc && thr_q[i].tid == tid) fi = i;
        end
        if (fi >= 0) begin
            logic [31:0] d;
            e = thr_q[fi];
            thr_q.delete(fi);
            d = addr - e.last;
            if (e.st == 0) begin
                e.stride = d; e.st = 1;
            end else if (d == e.stride) begin
                e.st = 2;
            end else begin
                e.stride = d; e.st = 1;
            end
            e.last = addr;
            thr_q.push_back(e);
        end else begin
            if (thr_q.size() == SN) void'(thr_q.pop_front());
            e.pc = pc; e.tid = tid; e.last = addr; e.stride = '0; e.st = 0;
            thr_q.push_back(e);
        end
        if (e.st == 2) begin
            r.hit = 1; r.addr = addr + e.stride;
            cnt = 0;
            for (int i = 0; i < thr_q.size(); i++) begin
                if (thr_q[i].pc == pc && thr_q[i].st == 2 && thr_q[i].stride == e.stride) cnt++;
            end
            if (cnt >= need_m) begin
                shr_t s;
                for (int i = thr_q.size() - 1; i >= 0; i--) begin
                    if (thr_q[i].pc == pc && thr_q[i].st == 2 && thr_q[i].stride == e.stride)
                        thr_q.delete(i);
                end
                if (shr_q.size() == PN) void'(shr_q.pop_front());
                s.pc = pc; s.stride = e.stride;
                shr_q.push_back(s);
            end
        end
        return r;
    endfunction

    // one clock: compare the response due now, then present the next access
    task automatic step(bit v, logic [31:0] pc, logic [7:0] tid, logic [31:0] addr, string tag);
        exp_t e;
        @(negedge clk);
        e = pipe[2];
        n_checks++;
        if (rsp_valid !== e.valid || (e.valid && (rsp_hit !== e.hit || rsp_promo !== e.promo
                || rsp_pf_addr !== e.addr)) || (!e.valid && rsp_hit !== 1'b0)) begin
            n_fail++;
            $display("FAIL %s: got v=%0b hit=%0b promo=%0b addr=%h, expected v=%0b hit=%0b promo=%0b addr=%h",
                     e.tag, rsp_valid, rsp_hit, rsp_promo, rsp_pf_addr,
                     e.valid, e.hit, e.promo, e.addr);
        end
        pipe[2] = pipe[1];
        pipe[1] = pipe[0];
        if (v) pipe[0] = model(pc, tid, addr, tag);
        else begin
            pipe[0].valid = 0; pipe[0].hit = 0; pipe[0].promo = 0; pipe[0].addr = '0;
            pipe[0].tag = tag;
        end
        req_valid = v; req_pc = pc; req_tid = tid; req_addr = addr;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(0, '0, '0, '0, tag);
    endtask

    task automatic set_need(int n);
        idle(3, "R5_flush");
        need_m = n;
        cfg_promo_need = NW'(n);
    endtask

    // train one thread at a PC with a fixed stride, k accesses from base
    task automatic walk(logic [31:0] pc, logic [7:0] tid, logic [31:0] base, logic [31:0] strd,
                        int k, string tag);
        for (int i = 0; i < k; i++) step(1, pc, tid, base + strd * i, tag);
    endtask

    int lastaddr [4][6];
    int pcstride [4];

    initial begin
        for (int i = 0; i < 3; i++) begin
            pipe[i].valid = 0; pipe[i].hit = 0; pipe[i].promo = 0; pipe[i].addr = '0;
            pipe[i].tag = "R1_reset";
        end
        repeat (4) @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_promo !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got v=%0b hit=%0b promo=%0b, expected 0 0 0", rsp_valid, rsp_hit, rsp_promo);
        end
        rst = 1'b0;
        idle(4, "R1_after_reset");

        // R3: train a single thread, stride 0x100
        walk(32'h100, 8'd1, 32'h1000, 32'h100, 4, "R3_train");
        // R4: stride change to 0x200 restarts training
        step(1, 32'h100, 8'd1, 32'h1500, "R4_change");
        step(1, 32'h100, 8'd1, 32'h1700, "R4_retrain");
        step(1, 32'h100, 8'd1, 32'h1900, "R4_locked");

        // R5 and R9: three threads agree on 64 at one PC, next access is a new thread
        walk(32'h200, 8'd2, 32'h0,    32'd64, 3, "R5_voter");
        walk(32'h200, 8'd3, 32'h8000, 32'd64, 3, "R5_voter");
        walk(32'h200, 8'd4, 32'h9000, 32'd64, 3, "R5_promote");
        step(1, 32'h200, 8'd7, 32'h5000, "R9_back_to_back");
        step(1, 32'h200, 8'd2, 32'h0c0,  "R6_old_thread");

        // R10: different strides at one PC never fold
        walk(32'h300, 8'd1, 32'h0, 32'd8,  3, "R10_a");
        walk(32'h300, 8'd2, 32'h0, 32'd16, 3, "R10_b");
        walk(32'h300, 8'd3, 32'h0, 32'd24, 3, "R10_c");
        step(1, 32'h300, 8'd9, 32'h40, "R10_no_shared");

        // R6: shared hits do not refresh or allocate per-thread entries
        idle(3, "R6_flush");
        for (int t = 0; t < SN; t++) walk(32'h400 + t, 8'd1, 32'h0, 32'd4, 3, "R6_fill");
        for (int t = 0; t < 6; t++) step(1, 32'h200, 8'(20 + t), 32'h100 * t, "R6_shared_hits");
        for (int t = 0; t < SN; t++) step(1, 32'h400 + t, 8'd1, 32'd12, "R6_kept");

        // R7: per-thread LRU eviction
        walk(32'h500, 8'd0, 32'h0, 32'd32, 3, "R7_victim");
        for (int t = 0; t < SN; t++) step(1, 32'h600, 8'(t), 32'h0, "R7_evictors");
        step(1, 32'h500, 8'd0, 32'd96, "R7_evicted");

        // R8: shared-table LRU with two voters needed
        set_need(2);
        for (int p = 0; p < PN + 1; p++) begin
            walk(32'h700 + 32'h10 * p, 8'd1, 32'h0,    32'd32, 3, "R8_build");
            walk(32'h700 + 32'h10 * p, 8'd2, 32'h4000, 32'd32, 3, "R8_build");
        end
        step(1, 32'h700, 8'd5, 32'h0, "R8_oldest_gone");
        step(1, 32'h700 + 32'h10 * PN, 8'd5, 32'h0, "R8_newest_kept");

        // mixed random traffic over few PCs and threads
        set_need(3);
        for (int p = 0; p < 4; p++) begin
            pcstride[p] = (p + 1) * 16;
            for (int t = 0; t < 6; t++) lastaddr[p][t] = t * 4096 + p * 256;
        end
        for (int i = 0; i < 3000; i++) begin
            int p;
            int t;
            int a;
            p = int'($urandom_range(0, 3));
            t = int'($urandom_range(0, 5));
            if ($urandom_range(0, 9) < 2) begin
                step(0, '0, '0, '0, "R2_gap");
            end else begin
                if ($urandom_range(0, 19) == 0) a = lastaddr[p][t] + 1000;
                else a = lastaddr[p][t] + pcstride[p];
                lastaddr[p][t] = a;
                step(1, 32'hA00 + p, 8'(t), 32'(a), "R2_R5_mixed");
            end
        end
        idle(4, "R2_drain");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule